// File: doc/BRIEF.md
# Integer Execute Stage with Register File

This block is the integer execute step of a 32-bit load/store processor core. Each cycle it may accept one already-decoded operation: an operation code, two source register indices, a destination index, a 26-bit immediate field and the address of the operation. It reads both sources from its own 32-entry register file and computes the result. It then registers the write-back outcome together with the address of the next operation to fetch.

The unit has no condition codes and no status word. Comparisons write a 1 or a 0 into a general register. Conditional branches test a single register against zero. Linking always targets the highest-numbered register. Register 0 is a constant zero.

A result is written into the register file on the same clock edge that loads the output registers. An operation issued in the very next cycle therefore reads the new value, and no forwarding is needed. Multiplication, division, floating point, memory access, traps and hazard handling are outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: For op_code 0 (add), 1 (unsigned add), 2 (subtract) and 3 (unsigned subtract), the unit writes register rs_a minus or plus the second operand, modulo 2^32, to register rd_idx. ovf_flag is 1 only for codes 0, 2, 16 and 18, and then only on two's-complement overflow.
- R2: Codes 4, 5 and 6 are bitwise AND, OR and XOR. Codes 16 to 31 are the immediate forms of codes 0 to 15: the second operand is imm_field[15:0]. It is zero-extended for codes 20, 21 and 22 and sign-extended for all other immediate codes.
- R3: Codes 7, 8 and 9 (immediate forms 23, 24, 25) shift rs_a left logically, right logically or right arithmetically. The shift amount is the low 5 bits of the second operand only.
- R4: Codes 10 to 15 (less, greater, less-or-equal, greater-or-equal, equal, not-equal) compare rs_a with the second operand as signed numbers. They write 1 when the relation holds and 0 otherwise. Immediate forms are codes 26 to 31.
- R5: Code 32 writes imm_field[15:0] into bits 31:16 of rd_idx and clears bits 15:0.
- R6: Codes 33 (branch if zero) and 34 (branch if non-zero) test rs_a. When taken, next_pc is pc_in+4 plus the sign-extended imm_field[15:0] and br_taken is 1. Otherwise next_pc is pc_in+4. Neither code writes a register.
- R7: Codes 35 (jump) and 36 (jump and link) set br_taken and next_pc = pc_in+4 plus the sign-extended 26-bit imm_field. Code 36 also writes pc_in+4 into register 31.
- R8: Codes 37 (jump register) and 38 (jump register and link) set br_taken and next_pc to the value of rs_a read before any write. Code 38 also writes pc_in+4 into register 31.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and wb_en stays 0 for it.
- R10: Outputs appear one cycle after an operation is accepted. A written value is seen by an operation issued in the next cycle. After reset, all outputs are 0 and all registers read 0.
- R11: With op_valid low, wb_valid, wb_en, br_taken, ovf_flag and next_pc are 0 in the following cycle. Codes 39 to 63 give wb_valid 1, no write, no branch and next_pc = pc_in+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Decoded operation code (see requirements) |
| rs_a_idx | input | 5 | First source register index |
| rs_b_idx | input | 5 | Second source register index |
| rd_idx | input | 5 | Destination register index |
| imm_field | input | 26 | Immediate; low 16 bits for immediate forms, all 26 for jumps |
| pc_in | input | 32 | Address of the operation |
| wb_valid | output | 1 | An operation completed last cycle |
| wb_en | output | 1 | A register was written |
| wb_idx | output | 5 | Index of the written register |
| wb_data | output | 32 | Value written |
| ovf_flag | output | 1 | Signed overflow of a signed add or subtract |
| br_taken | output | 1 | Control flow is redirected |
| next_pc | output | 32 | Address of the next operation |

## Verification
A register that holds a wrong value stays hidden until an operation reads it. It then shows up as a wrong wb_data, a wrong branch decision or a wrong jump target one cycle after that reading operation. The stimulus therefore reuses a small set of registers heavily, so that any stored value is read back within a few operations. A wrong operand extension, a shift that uses bit 5 of the amount, or a signed/unsigned mix-up in the compares shows in the cycle right after the offending operation. The directed cases cover overflow at the signed extremes, writes to register 0 followed by reads of it, a register-and-link jump through register 31, and back-to-back dependent operations.

// File: rtl/iex_pkg.sv
package iex_pkg;

    typedef enum logic [5:0] {
        OP_ADD   = 6'd0,  OP_ADDU  = 6'd1,  OP_SUB   = 6'd2,  OP_SUBU  = 6'd3,
        OP_AND   = 6'd4,  OP_OR    = 6'd5,  OP_XOR   = 6'd6,  OP_SLL   = 6'd7,
        OP_SRL   = 6'd8,  OP_SRA   = 6'd9,  OP_SLT   = 6'd10, OP_SGT   = 6'd11,
        OP_SLE   = 6'd12, OP_SGE   = 6'd13, OP_SEQ   = 6'd14, OP_SNE   = 6'd15,
        OP_ADDI  = 6'd16, OP_ADDUI = 6'd17, OP_SUBI  = 6'd18, OP_SUBUI = 6'd19,
        OP_LHI   = 6'd32, OP_BEQZ  = 6'd33, OP_BNEZ  = 6'd34, OP_J     = 6'd35,
        OP_JAL   = 6'd36, OP_JR    = 6'd37, OP_JALR  = 6'd38
    } iex_op_e;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,  FN_ADDU = 4'd1,  FN_SUB  = 4'd2,  FN_SUBU = 4'd3,
        FN_AND  = 4'd4,  FN_OR   = 4'd5,  FN_XOR  = 4'd6,  FN_SLL  = 4'd7,
        FN_SRL  = 4'd8,  FN_SRA  = 4'd9,  FN_SLT  = 4'd10, FN_SGT  = 4'd11,
        FN_SLE  = 4'd12, FN_SGE  = 4'd13, FN_SEQ  = 4'd14, FN_SNE  = 4'd15
    } iex_fn_e;

endpackage

// File: rtl/iex_regfile.sv
module iex_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_a_data,
    output logic [XLEN-1:0]  rd_b_data
);

    // Entry 0 has no storage; it is the constant zero.
    logic [XLEN-1:0] bank [1:NREGS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREGS; i++) begin
                bank[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            bank[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int i = 1; i < NREGS; i++) begin
            if (rd_a_idx == IDX_W'(i)) rd_a_data = bank[i];
            if (rd_b_idx == IDX_W'(i)) rd_b_data = bank[i];
        end
    end

    // R10: a value written at one edge is what the next read of that entry returns
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0)) |=>
            ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

endmodule

// File: rtl/iex_shifter.sv
module iex_shifter #(
    parameter int XLEN = 32,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SH_W-1:0] amt,
    input  logic            go_left,
    input  logic            arith,
    output logic [XLEN-1:0] dout
);

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] shr;
    logic            fill;

    // A left shift is a right shift of the bit-reversed word.
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            src[i] = go_left ? din[XLEN-1-i] : din[i];
        end
    end

    assign fill = arith & ~go_left & din[XLEN-1];

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [XLEN-1:0] d_in;
        logic [XLEN-1:0] q;
        if (s == 0) begin : g_first
            assign d_in = src;
        end else begin : g_next
            assign d_in = g_stage[s-1].q;
        end
        assign q = amt[s] ? {{STEP{fill}}, d_in[XLEN-1:STEP]} : d_in;
    end

    assign shr = g_stage[SH_W-1].q;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            dout[i] = go_left ? shr[XLEN-1-i] : shr[i];
        end
    end

endmodule

// File: rtl/iex_alu.sv
module iex_alu
    import iex_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  iex_fn_e         fn,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] result,
    output logic            raw_ovf
);

    logic            sub_mode;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic            lt_s;
    logic            eq;

    assign sub_mode = (fn == FN_SUB) || (fn == FN_SUBU);
    assign b_eff    = sub_mode ? ~opb : opb;
    assign sum      = opa + b_eff + XLEN'(sub_mode);
    assign raw_ovf  = (opa[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != opa[XLEN-1]);
    assign lt_s     = $signed(opa) < $signed(opb);
    assign eq       = (opa == opb);

    always_comb begin
        result = '0;
        unique case (fn)
            FN_ADD, FN_ADDU, FN_SUB, FN_SUBU: result = sum;
            FN_AND:  result = opa & opb;
            FN_OR:   result = opa | opb;
            FN_XOR:  result = opa ^ opb;
            FN_SLT:  result = XLEN'(lt_s);
            FN_SGT:  result = XLEN'(!lt_s && !eq);
            FN_SLE:  result = XLEN'(lt_s || eq);
            FN_SGE:  result = XLEN'(!lt_s);
            FN_SEQ:  result = XLEN'(eq);
            FN_SNE:  result = XLEN'(!eq);
            FN_SLL, FN_SRL, FN_SRA: result = '0;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/iex_flow.sv
module iex_flow
    import iex_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int OFF_W = 26
) (
    input  logic [5:0]       op_code,
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  cond_val,
    input  logic [OFF_W-1:0] imm_field,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  link_addr
);

    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] br_dest;
    logic [XLEN-1:0] jmp_dest;
    logic            is_zero;

    assign pc_seq    = pc + XLEN'(4);
    assign link_addr = pc_seq;
    assign br_dest   = pc_seq + {{(XLEN-IMM_W){imm_field[IMM_W-1]}}, imm_field[IMM_W-1:0]};
    assign jmp_dest  = pc_seq + {{(XLEN-OFF_W){imm_field[OFF_W-1]}}, imm_field};
    assign is_zero   = (cond_val == '0);

    always_comb begin
        taken  = 1'b0;
        target = pc_seq;
        case (op_code)
            OP_BEQZ: begin
                taken  = is_zero;
                target = is_zero ? br_dest : pc_seq;
            end
            OP_BNEZ: begin
                taken  = !is_zero;
                target = is_zero ? pc_seq : br_dest;
            end
            OP_J, OP_JAL: begin
                taken  = 1'b1;
                target = jmp_dest;
            end
            OP_JR, OP_JALR: begin
                taken  = 1'b1;
                target = cond_val;
            end
            default: begin
                taken  = 1'b0;
                target = pc_seq;
            end
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iex_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int IMM_W = 16,
    parameter int OFF_W = 26,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [5:0]       op_code,
    input  logic [IDX_W-1:0] rs_a_idx,
    input  logic [IDX_W-1:0] rs_b_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [OFF_W-1:0] imm_field,
    input  logic [XLEN-1:0]  pc_in,
    output logic             wb_valid,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             ovf_flag,
    output logic             br_taken,
    output logic [XLEN-1:0]  next_pc
);

    localparam int SH_W = $clog2(XLEN);
    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(NREGS - 1);

    logic [XLEN-1:0]  rs_a_data, rs_b_data;
    logic [XLEN-1:0]  imm_sx, imm_zx, opnd_b;
    logic [XLEN-1:0]  alu_res, sh_res, fl_target, fl_link;
    logic             alu_ovf, fl_taken;
    iex_fn_e          fn;
    logic             reg_class, imm_form, is_logic, is_shift, signed_arith;

    logic             n_valid, n_en, n_ovf, n_taken, n_write;
    logic [IDX_W-1:0] n_idx;
    logic [XLEN-1:0]  n_data, n_npc;

    // ---- decode ----
    assign reg_class    = !op_code[5];
    assign imm_form     = op_code[4];
    assign fn           = iex_fn_e'(op_code[3:0]);
    assign is_logic     = (fn == FN_AND) || (fn == FN_OR) || (fn == FN_XOR);
    assign is_shift     = (fn == FN_SLL) || (fn == FN_SRL) || (fn == FN_SRA);
    assign signed_arith = (fn == FN_ADD) || (fn == FN_SUB);
    assign imm_sx       = {{(XLEN-IMM_W){imm_field[IMM_W-1]}}, imm_field[IMM_W-1:0]};
    assign imm_zx       = {{(XLEN-IMM_W){1'b0}}, imm_field[IMM_W-1:0]};
    assign opnd_b       = !imm_form ? rs_b_data : (is_logic ? imm_zx : imm_sx);

    // ---- datapath pieces ----
    iex_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (rs_a_idx),
        .rd_b_idx  (rs_b_idx),
        .wr_en     (n_en),
        .wr_idx    (n_idx),
        .wr_data   (n_data),
        .rd_a_data (rs_a_data),
        .rd_b_data (rs_b_data)
    );

    iex_alu #(.XLEN(XLEN)) u_alu (
        .fn      (fn),
        .opa     (rs_a_data),
        .opb     (opnd_b),
        .result  (alu_res),
        .raw_ovf (alu_ovf)
    );

    iex_shifter #(.XLEN(XLEN)) u_shifter (
        .din     (rs_a_data),
        .amt     (opnd_b[SH_W-1:0]),
        .go_left (fn == FN_SLL),
        .arith   (fn == FN_SRA),
        .dout    (sh_res)
    );

    iex_flow #(.XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_flow (
        .op_code   (op_code),
        .pc        (pc_in),
        .cond_val  (rs_a_data),
        .imm_field (imm_field),
        .taken     (fl_taken),
        .target    (fl_target),
        .link_addr (fl_link)
    );

    // ---- next-value selection ----
    always_comb begin
        n_valid = 1'b0;
        n_write = 1'b0;
        n_idx   = '0;
        n_data  = '0;
        n_ovf   = 1'b0;
        n_taken = 1'b0;
        n_npc   = '0;
        if (op_valid) begin
            n_valid = 1'b1;
            n_taken = fl_taken;
            n_npc   = fl_target;
            if (reg_class) begin
                n_write = 1'b1;
                n_idx   = rd_idx;
                n_data  = is_shift ? sh_res : alu_res;
                n_ovf   = signed_arith & alu_ovf;
            end else begin
                case (op_code)
                    OP_LHI: begin
                        n_write = 1'b1;
                        n_idx   = rd_idx;
                        n_data  = {imm_field[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
                    end
                    OP_JAL, OP_JALR: begin
                        n_write = 1'b1;
                        n_idx   = LINK_IDX;
                        n_data  = fl_link;
                    end
                    default: n_write = 1'b0;
                endcase
            end
        end
        n_en = n_write && (n_idx != '0);
    end

    // ---- output registers ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_en    <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
            ovf_flag <= 1'b0;
            br_taken <= 1'b0;
            next_pc  <= '0;
        end else begin
            wb_valid <= n_valid;
            wb_en    <= n_en;
            wb_idx   <= n_idx;
            wb_data  <= n_data;
            ovf_flag <= n_ovf;
            br_taken <= n_taken;
            next_pc  <= n_npc;
        end
    end

    // ---- assertions ----
    // R1
    unsigned_noovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_code == OP_ADDU) || (op_code == OP_SUBU) ||
                      (op_code == OP_ADDUI) || (op_code == OP_SUBUI))) |=> !ovf_flag);

    // R4
    set_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_code[5] && (op_code[3:0] >= 4'd10)) |=> (wb_data[XLEN-1:1] == '0));

    // R5
    lhi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_LHI)) |=>
            (wb_data == {$past(imm_field[IMM_W-1:0]), {(XLEN-IMM_W){1'b0}}}));

    // R6
    notaken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_BEQZ) && (rs_a_data != '0)) |=>
            (!br_taken && !wb_en && (next_pc == $past(pc_in) + XLEN'(4))));

    // R7 and R8
    link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_code == OP_JAL) || (op_code == OP_JALR))) |=>
            (wb_en && (wb_idx == LINK_IDX) && (wb_data == $past(pc_in) + XLEN'(4))));

    // R9
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ADD) && (rs_a_idx == '0) && (rs_b_idx == '0)) |=>
            ((wb_data == '0) && !ovf_flag));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wb_valid && !wb_en && !br_taken && !ovf_flag));

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [4:0]  rs_a_idx = '0, rs_b_idx = '0, rd_idx = '0;
    logic [25:0] imm_field = '0;
    logic [31:0] pc_in = '0;
    logic        wb_valid, wb_en, ovf_flag, br_taken;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data, next_pc;

    int checks = 0;
    int failures = 0;
    logic [31:0] mregs [32];

    always #5 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rs_a_idx(rs_a_idx), .rs_b_idx(rs_b_idx), .rd_idx(rd_idx),
        .imm_field(imm_field), .pc_in(pc_in), .wb_valid(wb_valid), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_data(wb_data), .ovf_flag(ovf_flag),
        .br_taken(br_taken), .next_pc(next_pc)
    );

    function automatic string req_of(input logic [5:0] op);
        if (op < 6'd32) begin
            case (op[3:0])
                4'd0, 4'd1, 4'd2, 4'd3: return "R1";
                4'd4, 4'd5, 4'd6:       return "R2";
                4'd7, 4'd8, 4'd9:       return "R3";
                default:                return "R4";
            endcase
        end
        case (op)
            6'd32:        return "R5";
            6'd33, 6'd34: return "R6";
            6'd35, 6'd36: return "R7";
            6'd37, 6'd38: return "R8";
            default:      return "R11";
        endcase
    endfunction

    // Expected outcome straight from the requirement text.
    task automatic predict(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b,
                           input logic [4:0] d, input logic [25:0] imm, input logic [31:0] pc,
                           output logic e_we, output logic [4:0] e_idx, output logic [31:0] e_data,
                           output logic e_ovf, output logic e_tk, output logic [31:0] e_npc);
        logic [31:0] va, vb, s16, z16, s26, x;
        logic [3:0]  f;
        logic        wr;
        va = mregs[a];
        s16 = {{16{imm[15]}}, imm[15:0]};
        z16 = {16'h0, imm[15:0]};
        s26 = {{6{imm[25]}}, imm};
        f = op[3:0];
        wr = 1'b0; e_idx = d; e_data = '0; e_ovf = 1'b0; e_tk = 1'b0; e_npc = pc + 32'd4;
        if (op < 6'd32) begin
            if (op[4]) vb = (f >= 4'd4 && f <= 4'd6) ? z16 : s16;
            else       vb = mregs[b];
            wr = 1'b1;
            case (f)
                4'd0, 4'd1: begin
                    x = va + vb;
                    e_ovf = (f == 4'd0) && (va[31] == vb[31]) && (x[31] != va[31]);
                end
                4'd2, 4'd3: begin
                    x = va - vb;
                    e_ovf = (f == 4'd2) && (va[31] != vb[31]) && (x[31] != va[31]);
                end
                4'd4:  x = va & vb;
                4'd5:  x = va | vb;
                4'd6:  x = va ^ vb;
                4'd7:  x = va << vb[4:0];
                4'd8:  x = va >> vb[4:0];
                4'd9:  x = 32'($signed(va) >>> vb[4:0]);
                4'd10: x = {31'b0, $signed(va) <  $signed(vb)};
                4'd11: x = {31'b0, $signed(va) >  $signed(vb)};
                4'd12: x = {31'b0, $signed(va) <= $signed(vb)};
                4'd13: x = {31'b0, $signed(va) >= $signed(vb)};
                4'd14: x = {31'b0, va == vb};
                default: x = {31'b0, va != vb};
            endcase
            e_data = x;
        end else begin
            case (op)
                6'd32: begin wr = 1'b1; e_data = {imm[15:0], 16'h0}; end
                6'd33: begin e_tk = (va == 0);  if (e_tk) e_npc = pc + 32'd4 + s16; end
                6'd34: begin e_tk = (va != 0);  if (e_tk) e_npc = pc + 32'd4 + s16; end
                6'd35: begin e_tk = 1'b1; e_npc = pc + 32'd4 + s26; end
                6'd36: begin e_tk = 1'b1; e_npc = pc + 32'd4 + s26;
                             wr = 1'b1; e_idx = 5'd31; e_data = pc + 32'd4; end
                6'd37: begin e_tk = 1'b1; e_npc = va; end
                6'd38: begin e_tk = 1'b1; e_npc = va;
                             wr = 1'b1; e_idx = 5'd31; e_data = pc + 32'd4; end
                default: ;
            endcase
        end
        e_we = wr && (e_idx != 5'd0);
    endtask

    // Drive one operation right after a falling edge; check at the next falling edge.
    task automatic issue(input string tag, input logic [5:0] op, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d, input logic [25:0] imm,
                         input logic [31:0] pc);
        logic e_we, e_ovf, e_tk;
        logic [4:0] e_idx;
        logic [31:0] e_data, e_npc;
        string t;
        t = (tag == "") ? req_of(op) : tag;
        predict(op, a, b, d, imm, pc, e_we, e_idx, e_data, e_ovf, e_tk, e_npc);
        op_valid = 1'b1; op_code = op; rs_a_idx = a; rs_b_idx = b; rd_idx = d;
        imm_field = imm; pc_in = pc;
        if (e_we) mregs[e_idx] = e_data;
        @(negedge clk);
        checks++;
        if (!(wb_valid && wb_en == e_we && ovf_flag == e_ovf && br_taken == e_tk &&
              next_pc == e_npc && (!e_we || (wb_idx == e_idx && wb_data == e_data)))) begin
            failures++;
            $display("FAIL %s op=%0d actual v=%b en=%b idx=%0d data=%h ovf=%b tk=%b npc=%h expected en=%b idx=%0d data=%h ovf=%b tk=%b npc=%h",
                     t, op, wb_valid, wb_en, wb_idx, wb_data, ovf_flag, br_taken, next_pc,
                     e_we, e_idx, e_data, e_ovf, e_tk, e_npc);
        end
    endtask

    task automatic bubble(input string tag);
        op_valid = 1'b0;
        op_code = 6'd36; rd_idx = 5'd31; rs_a_idx = 5'd31;
        @(negedge clk);
        checks++;
        if (wb_valid || wb_en || br_taken || ovf_flag || next_pc != 32'd0) begin
            failures++;
            $display("FAIL %s idle actual v=%b en=%b tk=%b ovf=%b npc=%h expected all zero",
                     tag, wb_valid, wb_en, br_taken, ovf_flag, next_pc);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] seed_init;
        for (int i = 0; i < 32; i++) mregs[i] = '0;
        seed_init = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        checks++;
        if (wb_valid || wb_en || br_taken || ovf_flag || next_pc != 0 || wb_data != 0) begin
            failures++;
            $display("FAIL R10 reset actual v=%b en=%b npc=%h data=%h expected zeros",
                     wb_valid, wb_en, next_pc, wb_data);
        end
        issue("R10", 6'd0, 5'd3, 5'd7, 5'd1, 26'd0, 32'h100);          // regs read 0
        // building constants, sign/zero extension (R2, R5)
        issue("R5", 6'd32, 5'd0, 5'd0, 5'd2, 26'h7fff, 32'h104);       // r2 = 7fff0000
        issue("R2", 6'd21, 5'd2, 5'd0, 5'd2, 26'hffff, 32'h108);       // r2 = 7fffffff
        issue("R2", 6'd16, 5'd0, 5'd0, 5'd3, 26'h8001, 32'h10c);       // r3 = ffff8001
        issue("R2", 6'd20, 5'd3, 5'd0, 5'd4, 26'hff00, 32'h110);       // zero-extended and
        issue("R10", 6'd16, 5'd0, 5'd0, 5'd5, 26'd1, 32'h114);         // r5 = 1
        // R1: overflow at the signed extremes
        issue("R1", 6'd0, 5'd2, 5'd5, 5'd6, 26'd0, 32'h118);           // overflow
        issue("R1", 6'd1, 5'd2, 5'd5, 5'd7, 26'd0, 32'h11c);           // unsigned: none
        issue("R1", 6'd2, 5'd6, 5'd5, 5'd8, 26'd0, 32'h120);           // 80000000-1
        issue("R1", 6'd18, 5'd6, 5'd0, 5'd9, 26'd1, 32'h124);          // immediate form
        // R3: amount uses only low 5 bits
        issue("R3", 6'd25, 5'd3, 5'd0, 5'd10, 26'h21, 32'h128);
        issue("R3", 6'd23, 5'd5, 5'd0, 5'd11, 26'h3f, 32'h12c);
        issue("R3", 6'd24, 5'd3, 5'd0, 5'd12, 26'h20, 32'h130);
        // R4: signed ordering
        issue("R4", 6'd10, 5'd3, 5'd5, 5'd13, 26'd0, 32'h134);
        issue("R4", 6'd29, 5'd3, 5'd0, 5'd13, 26'h8001, 32'h138);
        issue("R4", 6'd11, 5'd2, 5'd6, 5'd14, 26'd0, 32'h13c);
        // R9: write to r0 dropped, then read back
        issue("R9", 6'd16, 5'd0, 5'd0, 5'd0, 26'h55, 32'h140);
        issue("R9", 6'd0, 5'd0, 5'd0, 5'd15, 26'd0, 32'h144);
        issue("R9", 6'd33, 5'd0, 5'd0, 5'd0, 26'h3ffc, 32'h148);
        // R6, R7, R8 directed
        issue("R6", 6'd34, 5'd3, 5'd0, 5'd0, 26'hfff0, 32'h200);
        issue("R6", 6'd33, 5'd3, 5'd0, 5'd0, 26'h0010, 32'h204);
        issue("R7", 6'd36, 5'd0, 5'd0, 5'd0, 26'h3fffff0, 32'h300);
        issue("R8", 6'd38, 5'd31, 5'd0, 5'd0, 26'd0, 32'h400);         // reads old r31
        issue("R8", 6'd37, 5'd31, 5'd0, 5'd0, 26'd0, 32'h404);
        // R11
        issue("R11", 6'd45, 5'd2, 5'd3, 5'd4, 26'h1234, 32'h500);
        bubble("R11");
        // random mix over a small register set
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r_imm, r_pc;
            logic [5:0]  r_op;
            r_op  = 6'($urandom_range(0, 44));
            r_imm = $urandom();
            r_pc  = $urandom() & 32'hffff_fffc;
            if ($urandom_range(0, 19) == 0) bubble("R11");
            else issue("", r_op, 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                       5'($urandom_range(0, 7)), r_imm[25:0], r_pc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule